// File: doc/BRIEF.md
# Secret-Tagged Load Forwarding Gate

This block sits between the load unit and the result bypass network of an out-of-order core. Every translated load completion reaches it together with a one-bit secrecy tag taken from the page it touched, and with a mask of the branches older than the load that are still unresolved. A load from an ordinary page goes straight through to the bypass port in the cycle it arrives. A load from a page tagged as possibly secret has already read memory, but its value is parked in a small hold queue and not handed to dependents while any older branch is still outstanding.

Branch outcomes arrive one per cycle as a tag plus a flag that says whether the branch was predicted correctly or must be squashed. A correct outcome clears that branch's bit in every held mask, and an entry whose mask is empty leaves through the single bypass port, oldest arrival first. A squash throws away every held entry that depended on the branch, and their values are never forwarded. The only storage is the hold queue. When the queue is full the gate pushes back on tagged completions so that none is lost.

Top module: `secure_fwd_gate`

## Requirements
- R1: A completion with the secrecy tag clear (`ldNs`=0) is presented on the bypass port in the same cycle, with `fwdHeld`=0, its destination on `fwdDest` and its value on `fwdData`. `ldReady` is always 1 for such a completion.
- R2: A completion with the secrecy tag set (`ldNs`=1) and a non-zero older-branch mask produces no bypass output while any bit of its mask is still set.
- R3: A correct outcome (`brValid`=1, `brSquash`=0) for tag b clears bit b of every held mask at the clock edge. An entry whose last bit is cleared this way is forwarded in the next cycle with `fwdHeld`=1, at the earliest.
- R4: A tagged completion whose mask is zero, after any correct outcome in the same cycle has been removed from it, is held for one edge and forwarded in the following cycle with `fwdHeld`=1.
- R5: A squash (`brValid`=1, `brSquash`=1) for tag b discards every held entry with mask bit b set. It also discards a tagged completion in the same cycle whose incoming mask has bit b set. None of these is ever forwarded.
- R6: When several held entries are releasable, one is forwarded per cycle, in the order in which they arrived.
- R7: When an untagged completion and a releasable held entry meet in the same cycle, the untagged completion takes the port. The held entry stays and goes out in a later cycle.
- R8: The hold queue keeps 8 entries. With 8 entries held, `ldReady` is 0 while `ldNs`=1, and a completion offered then is not taken.
- R9: Reset empties the hold queue. After reset `fwdValid` is 0 and `ldReady` is 1, and no entry held before the reset is ever forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| ldValid | input | 1 | Load completion present |
| ldNs | input | 1 | Page secrecy tag of the completion |
| ldDest | input | DEST_W | Destination register tag |
| ldData | input | DATA_W | Loaded value |
| ldMask | input | NUM_BR | Unresolved branches older than the load |
| ldReady | output | 1 | Completion accepted this cycle |
| brValid | input | 1 | Branch outcome present |
| brSquash | input | 1 | 1 = mispredicted (squash), 0 = correct |
| brTag | input | BT_W | Branch tag of the outcome |
| fwdValid | output | 1 | Bypass port carries a result |
| fwdHeld | output | 1 | Result came from the hold queue |
| fwdDest | output | DEST_W | Destination tag of the forwarded result |
| fwdData | output | DATA_W | Forwarded value |

## Verification
The gate is driven with interleaved streams of untagged and tagged completions under several branch patterns. Branches are resolved one bit at a time, and some are resolved in the same cycle that a tagged load arrives. This separates a mask that is cleared at the edge from one that is read too early. Squashes are aimed at entries that share a branch with survivors, and at a completion arriving in the same cycle, to show that only the dependent entries vanish. Collisions between untagged and released results, several entries becoming free together, a completely full queue and a reset over held entries probe the port priority, the arrival ordering, the back-pressure and the clearing of state.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  parameter int SFG_DEPTH  = 8;   // hold-queue entries
  parameter int SFG_NUM_BR = 8;   // branch tags in flight

  // strobes from control to datapath
  typedef struct packed {
    logic [SFG_DEPTH-1:0]  relVec;    // one-hot entry to forward
    logic [SFG_DEPTH-1:0]  dropVec;   // entries killed by a squash
    logic                  enq;       // write incoming tagged load
    logic                  passThru;  // incoming untagged load owns port
    logic [SFG_NUM_BR-1:0] clrMask;   // branch bit resolved correctly
  } sfg_strobe_t;
endpackage

// File: rtl/sfg_ctrl.sv
module sfg_ctrl
  import sfg_pkg::*;
#(
  parameter int DEPTH  = SFG_DEPTH,
  parameter int NUM_BR = SFG_NUM_BR,
  localparam int BT_W  = $clog2(NUM_BR)
) (
  input  logic              ldValid,
  input  logic              ldNs,
  input  logic [NUM_BR-1:0] ldMask,
  input  logic              brValid,
  input  logic              brSquash,
  input  logic [BT_W-1:0]   brTag,
  input  logic [DEPTH-1:0]  validVec,
  input  logic [DEPTH-1:0]  zeroVec,
  input  logic [DEPTH-1:0]  hitVec,
  output logic              ldReady,
  output sfg_strobe_t       strobe
);
  logic queueFull, accept, squashNow, resolveNow;

  assign queueFull  = &validVec;
  assign ldReady    = !queueFull || !ldNs;
  assign accept     = ldValid && ldReady;
  assign squashNow  = brValid && brSquash;
  assign resolveNow = brValid && !brSquash;

  always_comb begin
    strobe          = '0;
    strobe.passThru = accept && !ldNs;
    strobe.enq      = accept && ldNs && !(squashNow && ldMask[brTag]);
    strobe.dropVec  = squashNow ? hitVec : '0;
    if (resolveNow) strobe.clrMask[brTag] = 1'b1;
    // lowest index = oldest arrival; untagged result wins the port
    if (!strobe.passThru) strobe.relVec = zeroVec & (~zeroVec + 1'b1);
  end
endmodule

// File: rtl/sfg_datapath.sv
module sfg_datapath
  import sfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 6,
  parameter int DEPTH  = SFG_DEPTH,
  parameter int NUM_BR = SFG_NUM_BR,
  localparam int BT_W  = $clog2(NUM_BR),
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = IW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfg_strobe_t       strobe,
  input  logic [DEST_W-1:0] ldDest,
  input  logic [DATA_W-1:0] ldData,
  input  logic [NUM_BR-1:0] ldMask,
  input  logic [BT_W-1:0]   brTag,
  output logic [DEPTH-1:0]  validVec,
  output logic [DEPTH-1:0]  zeroVec,
  output logic [DEPTH-1:0]  hitVec,
  output logic              fwdValid,
  output logic              fwdHeld,
  output logic [DEST_W-1:0] fwdDest,
  output logic [DATA_W-1:0] fwdData
);
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [DEST_W-1:0] destQ [DEPTH];
  logic [NUM_BR-1:0] maskQ [DEPTH];
  logic [DEPTH-1:0]  validQ;

  logic [DATA_W-1:0] dataN [DEPTH];
  logic [DEST_W-1:0] destN [DEPTH];
  logic [NUM_BR-1:0] maskN [DEPTH];
  logic [DEPTH-1:0]  validN;
  logic [DEPTH-1:0]  keepVec;

  assign validVec = validQ;

  for (genvar i = 0; i < DEPTH; i++) begin : g_flags
    assign zeroVec[i] = validQ[i] && (maskQ[i] == '0);
    assign hitVec[i]  = validQ[i] && maskQ[i][brTag];
    assign keepVec[i] = validQ[i] && !strobe.dropVec[i] && !strobe.relVec[i];
  end

  // compact survivors toward index 0, append new entry behind them
  always_comb begin
    logic [CW-1:0] cnt;
    cnt    = '0;
    validN = '0;
    for (int i = 0; i < DEPTH; i++) begin
      dataN[i] = '0;
      destN[i] = '0;
      maskN[i] = '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (keepVec[i]) begin
        dataN[cnt[IW-1:0]]  = dataQ[i];
        destN[cnt[IW-1:0]]  = destQ[i];
        maskN[cnt[IW-1:0]]  = maskQ[i] & ~strobe.clrMask;
        validN[cnt[IW-1:0]] = 1'b1;
        cnt = cnt + CW'(1);
      end
    end
    if (strobe.enq && (cnt < CW'(DEPTH))) begin
      dataN[cnt[IW-1:0]]  = ldData;
      destN[cnt[IW-1:0]]  = ldDest;
      maskN[cnt[IW-1:0]]  = ldMask & ~strobe.clrMask;
      validN[cnt[IW-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      validQ <= validN;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      dataQ[i] <= dataN[i];
      destQ[i] <= destN[i];
      maskQ[i] <= maskN[i];
    end
  end

  // bypass port mux
  always_comb begin
    logic [DATA_W-1:0] relData;
    logic [DEST_W-1:0] relDest;
    relData = '0;
    relDest = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (strobe.relVec[i]) begin
        relData = relData | dataQ[i];
        relDest = relDest | destQ[i];
      end
    end
    fwdValid = strobe.passThru || (|strobe.relVec);
    fwdHeld  = !strobe.passThru && (|strobe.relVec);
    fwdData  = strobe.passThru ? ldData : relData;
    fwdDest  = strobe.passThru ? ldDest : relDest;
  end
endmodule

// File: rtl/secure_fwd_gate.sv
module secure_fwd_gate
  import sfg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 6,
  localparam int DEPTH  = SFG_DEPTH,
  localparam int NUM_BR = SFG_NUM_BR,
  localparam int BT_W   = $clog2(NUM_BR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic              ldNs,
  input  logic [DEST_W-1:0] ldDest,
  input  logic [DATA_W-1:0] ldData,
  input  logic [NUM_BR-1:0] ldMask,
  output logic              ldReady,
  input  logic              brValid,
  input  logic              brSquash,
  input  logic [BT_W-1:0]   brTag,
  output logic              fwdValid,
  output logic              fwdHeld,
  output logic [DEST_W-1:0] fwdDest,
  output logic [DATA_W-1:0] fwdData
);
  sfg_strobe_t      strobe;
  logic [DEPTH-1:0] validVec, zeroVec, hitVec;

  sfg_ctrl #(.DEPTH(DEPTH), .NUM_BR(NUM_BR)) ctrl_i (
    .ldValid(ldValid), .ldNs(ldNs), .ldMask(ldMask),
    .brValid(brValid), .brSquash(brSquash), .brTag(brTag),
    .validVec(validVec), .zeroVec(zeroVec), .hitVec(hitVec),
    .ldReady(ldReady), .strobe(strobe)
  );

  sfg_datapath #(.DATA_W(DATA_W), .DEST_W(DEST_W), .DEPTH(DEPTH), .NUM_BR(NUM_BR)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ldDest(ldDest), .ldData(ldData), .ldMask(ldMask), .brTag(brTag),
    .validVec(validVec), .zeroVec(zeroVec), .hitVec(hitVec),
    .fwdValid(fwdValid), .fwdHeld(fwdHeld), .fwdDest(fwdDest), .fwdData(fwdData)
  );
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ldValid,
  input logic              ldNs,
  input logic              ldReady,
  input logic [DATA_W-1:0] ldData,
  input logic              fwdValid,
  input logic              fwdHeld,
  input logic [DATA_W-1:0] fwdData,
  input logic [DEPTH-1:0]  validVec,
  input logic [DEPTH-1:0]  zeroVec,
  input logic [DEPTH-1:0]  relVec
);
  AST_UNTAGGED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && !ldNs) |-> (ldReady && fwdValid && !fwdHeld && fwdData == ldData)); // R1

  AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (relVec & ~zeroVec) == '0); // R3

  AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(relVec)); // R6

  AST_QUEUE_PACKED: assert property (@(posedge clk) disable iff (!rstN)
    ((validVec + 1'b1) & validVec) == '0); // R6

  AST_UNTAGGED_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    fwdHeld |-> !(ldValid && !ldNs)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (ldNs && !ldReady) |-> (&validVec)); // R8

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !$past(rstN) |-> (validVec == '0)); // R9
endmodule

bind secure_fwd_gate sfg_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldNs(ldNs), .ldReady(ldReady),
  .ldData(ldData), .fwdValid(fwdValid), .fwdHeld(fwdHeld), .fwdData(fwdData),
  .validVec(validVec), .zeroVec(zeroVec), .relVec(strobe.relVec)
);

// File: tb/secure_fwd_gate_tb.sv
`timescale 1ns/1ps
module secure_fwd_gate_tb_top;
  localparam int DATA_W = 32;
  localparam int DEST_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldValid = 1'b0, ldNs = 1'b0, brValid = 1'b0, brSquash = 1'b0;
  logic [DEST_W-1:0] ldDest = '0;
  logic [DATA_W-1:0] ldData = '0;
  logic [7:0] ldMask = '0;
  logic [2:0] brTag = '0;
  logic ldReady, fwdValid, fwdHeld;
  logic [DEST_W-1:0] fwdDest;
  logic [DATA_W-1:0] fwdData;

  int nTests = 0;
  int nFail = 0;

  always #2 clk = ~clk;  // 250 MHz

  secure_fwd_gate #(.DATA_W(DATA_W), .DEST_W(DEST_W)) dut_i (.*);

  function automatic logic [DATA_W-1:0] valOf(input logic [DEST_W-1:0] d);
    return 32'hC0DE_0000 | DATA_W'(d);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive inputs at falling edge, sample before the rising edge
  task automatic drive(input logic v, input logic ns, input logic [DEST_W-1:0] d,
                       input logic [7:0] m, input logic bv, input logic sq,
                       input logic [2:0] t);
    @(negedge clk);
    ldValid = v; ldNs = ns; ldDest = d; ldData = valOf(d); ldMask = m;
    brValid = bv; brSquash = sq; brTag = t;
    #1;
  endtask

  typedef struct packed {
    logic ldV; logic ns; logic [5:0] dest; logic [7:0] mask;
    logic brV; logic sq; logic [2:0] tag;
    logic eV; logic eH; logic [5:0] eD;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,6'd1, 8'h00,1'b0,1'b0,3'd0,1'b1,1'b0,6'd1},  // R1 untagged passes
    '{1'b1,1'b1,6'd2, 8'h03,1'b0,1'b0,3'd0,1'b0,1'b0,6'd0},  // R2 held
    '{1'b1,1'b1,6'd3, 8'h01,1'b1,1'b0,3'd0,1'b0,1'b0,6'd0},  // R4 mask cleared on arrival
    '{1'b0,1'b0,6'd0, 8'h00,1'b0,1'b0,3'd0,1'b1,1'b1,6'd3},  // R4 goes next cycle
    '{1'b0,1'b0,6'd0, 8'h00,1'b1,1'b0,3'd1,1'b0,1'b0,6'd0},  // R3 not before edge
    '{1'b1,1'b0,6'd4, 8'h00,1'b0,1'b0,3'd0,1'b1,1'b0,6'd4},  // R7 untagged wins
    '{1'b0,1'b0,6'd0, 8'h00,1'b0,1'b0,3'd0,1'b1,1'b1,6'd2},  // R3 R7 held goes now
    '{1'b1,1'b1,6'd5, 8'h04,1'b0,1'b0,3'd0,1'b0,1'b0,6'd0},  // R2
    '{1'b1,1'b1,6'd6, 8'h08,1'b0,1'b0,3'd0,1'b0,1'b0,6'd0},  // R2
    '{1'b1,1'b1,6'd7, 8'h0C,1'b0,1'b0,3'd0,1'b0,1'b0,6'd0},  // R2
    '{1'b0,1'b0,6'd0, 8'h00,1'b1,1'b1,3'd2,1'b0,1'b0,6'd0},  // R5 squash tag 2
    '{1'b1,1'b1,6'd9, 8'h10,1'b0,1'b0,3'd0,1'b0,1'b0,6'd0},  // R2
    '{1'b0,1'b0,6'd0, 8'h00,1'b1,1'b0,3'd3,1'b0,1'b0,6'd0},  // R3
    '{1'b1,1'b1,6'd10,8'h10,1'b1,1'b0,3'd4,1'b1,1'b1,6'd6},  // R5 survivor 6 out
    '{1'b0,1'b0,6'd0, 8'h00,1'b0,1'b0,3'd0,1'b1,1'b1,6'd9},  // R6 oldest first
    '{1'b0,1'b0,6'd0, 8'h00,1'b0,1'b0,3'd0,1'b1,1'b1,6'd10}, // R6 then next
    '{1'b0,1'b0,6'd0, 8'h00,1'b0,1'b0,3'd0,1'b0,1'b0,6'd0},  // R5 5 and 7 gone
    '{1'b1,1'b1,6'd11,8'h20,1'b1,1'b1,3'd5,1'b0,1'b0,6'd0},  // R5 same-cycle kill
    '{1'b0,1'b0,6'd0, 8'h00,1'b1,1'b0,3'd5,1'b0,1'b0,6'd0},  // R5
    '{1'b0,1'b0,6'd0, 8'h00,1'b0,1'b0,3'd0,1'b0,1'b0,6'd0}   // R5 never forwarded
  };

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; #1;
    chk("R9 reset fwdValid", 64'(fwdValid), 64'd0);
    chk("R9 reset ldReady", 64'(ldReady), 64'd1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.ldV, v.ns, v.dest, v.mask, v.brV, v.sq, v.tag);
      chk($sformatf("R1-7 row%0d fwdValid", i), 64'(fwdValid), 64'(v.eV));
      if (v.eV) begin
        chk($sformatf("row%0d fwdHeld", i), 64'(fwdHeld), 64'(v.eH));
        chk($sformatf("row%0d fwdDest", i), 64'(fwdDest), 64'(v.eD));
        chk($sformatf("row%0d fwdData", i), 64'(fwdData), 64'(valOf(v.eD)));
      end
    end

    // R8: fill all eight slots behind branch 7
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 1'b1, DEST_W'(20 + i), 8'h80, 1'b0, 1'b0, 3'd0);
      chk("R8 ready while filling", 64'(ldReady), 64'd1);
    end
    drive(1'b1, 1'b1, 6'd40, 8'h00, 1'b0, 1'b0, 3'd0);
    chk("R8 full blocks tagged", 64'(ldReady), 64'd0);
    chk("R8 full no output", 64'(fwdValid), 64'd0);
    drive(1'b1, 1'b0, 6'd41, 8'h00, 1'b0, 1'b0, 3'd0);
    chk("R8 R1 untagged ready when full", 64'(ldReady), 64'd1);
    chk("R8 R1 untagged forwarded", 64'(fwdDest), 64'd41);
    drive(1'b0, 1'b0, 6'd0, 8'h00, 1'b1, 1'b1, 3'd7);
    drive(1'b0, 1'b1, 6'd0, 8'h00, 1'b0, 1'b0, 3'd0);
    chk("R5 squash empties queue", 64'(ldReady), 64'd1);
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 3'd0);
      chk("R5 refused load 40 and squashed never forwarded", 64'(fwdValid), 64'd0);
    end

    // R9: reset drops a held entry
    drive(1'b1, 1'b1, 6'd50, 8'h01, 1'b0, 1'b0, 3'd0);
    drive(1'b0, 1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 3'd0);
    rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    drive(1'b0, 1'b0, 6'd0, 8'h00, 1'b1, 1'b0, 3'd0);
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b0, 6'd0, 8'h00, 1'b0, 1'b0, 3'd0);
      chk("R9 held entry cleared by reset", 64'(fwdValid), 64'd0);
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule